// File: doc/BRIEF.md
# Wrapping Burst Column Address Generator

This block turns one starting column address into the column sequence of a single read or write burst. It issues one column per beat. The burst length is picked from 1, 2, 4 or 8. The upper column bits select an aligned segment of the page, the size of one burst, and stay fixed for the whole burst. The lower bits start at the supplied position and count upward, wrapping modulo the burst length. Because of this wrap, the burst never leaves its segment, although it may start in the middle of it.

A controller pulses `start` with the starting column and the length code. The addresses then leave through a valid/ready stream. A beat counts as issued only in a cycle where `addr_valid` and `addr_ready` are both high. While `addr_ready` is low, the present column and last flag stay on the outputs unchanged. The producer never drops or skips a beat. A new `start` aborts any burst in progress, whatever the state of `addr_ready`, and the new burst appears on the following cycle. The page width is a parameter, and so is the width of the length code, which sets the longest burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `addr_valid` and `addr_last` are low, and they stay low until the first `start`.
- R2: In the cycle after `start` is sampled high, `addr_valid` is high and `col` equals the `start_col` sampled with it.
- R3: Within a burst, the column bits above the lowest log2(length) bits stay equal to those of the starting column.
- R4: Each accepted beat that is not the last one adds one to the lowest log2(length) bits, modulo the length. For example, start 2 with length 4 gives 2, 3, 0, 1.
- R5: `len_sel` encodes the length as 2^len_sel: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. The burst delivers exactly that many accepted beats. In the cycle after the final beat is accepted, `addr_valid` is low.
- R6: `addr_last` is high exactly with the final address of the burst and is never high while `addr_valid` is low.
- R7: While `addr_valid` is high and `addr_ready` is low, `col`, `addr_last` and `addr_valid` hold their values in the next cycle.
- R8: A `start` during an active burst abandons it. The next cycle shows the new starting column, and a full burst of the new length follows.
- R9: `start_col` and `len_sel` are sampled only with `start`. Changing them during a burst does not alter the columns that are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new burst (aborts any current one) |
| start_col | input | COL_W | Starting column of the burst |
| len_sel | input | SEL_W | Burst length code, length = 2^len_sel |
| addr_ready | input | 1 | Consumer accepts the current column |
| col | output | COL_W | Current column of the burst |
| addr_valid | output | 1 | `col` holds a beat of the burst |
| addr_last | output | 1 | Current beat is the final one |

## Verification
A wrong segment register or a wrong wrap mask shows as a bad column on the first beat that crosses the top of the segment. For a length-8 burst that starts at position 7, this is the second beat. A beat counter that is off by one makes `addr_last` appear a beat early or late, or leaves `addr_valid` high one cycle past the end, so the error is visible within one burst. A hold path that advances under back-pressure changes `col` in the cycle right after `addr_ready` drops, so the fault is seen in a single stall.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Length code: burst length is 2 ** code.
  typedef enum logic [1:0] {
    LEN_1 = 2'd0,
    LEN_2 = 2'd1,
    LEN_4 = 2'd2,
    LEN_8 = 2'd3
  } len_code_e;

  // Number of low wrapping bits needed for the longest length a code of
  // sel_w bits can select.
  function automatic int unsigned wrap_bits(input int unsigned sel_w);
    return (1 << sel_w) - 1;
  endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned LOW_W = 3
) (
  input  logic [SEL_W-1:0] len_sel,
  output logic [LOW_W-1:0] wrap_mask
);

  // Bit i of the mask is set when the length exceeds 2**i, so the mask
  // equals length-1 and also serves as the beat count minus one.
  for (genvar i = 0; i < LOW_W; i++) begin : g_mask
    assign wrap_mask[i] = (32'(len_sel) > i);
  end

  always_comb begin
    assert (wrap_mask == LOW_W'((1 << len_sel) - 1))
      else $error("assert_mask_shape_R5 length decode mismatch");
  end

endmodule

// File: rtl/burst_wrap_step.sv
module burst_wrap_step #(
  parameter int unsigned COL_W = 10,
  parameter int unsigned LOW_W = 3
) (
  input  logic [COL_W-1:0] cur_col,
  input  logic [LOW_W-1:0] wrap_mask,
  output logic [COL_W-1:0] next_col
);

  logic [LOW_W-1:0] low_inc;

  assign low_inc = cur_col[LOW_W-1:0] + LOW_W'(1);

  // Bits inside the mask take the incremented value, so the carry out of the
  // top masked bit is dropped; bits above the mask pass through unchanged.
  for (genvar i = 0; i < LOW_W; i++) begin : g_low
    assign next_col[i] = wrap_mask[i] ? low_inc[i] : cur_col[i];
  end

  if (COL_W > LOW_W) begin : g_upper
    assign next_col[COL_W-1:LOW_W] = cur_col[COL_W-1:LOW_W];
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned LOW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LOW_W-1:0] load_val,
  input  logic             advance,
  output logic             is_last
);

  logic [LOW_W-1:0] remaining_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining_q <= '0;
    end else if (load) begin
      remaining_q <= load_val;
    end else if (advance && remaining_q != '0) begin
      remaining_q <= remaining_q - LOW_W'(1);
    end
  end

  assign is_last = (remaining_q == '0);

  // R5: the count only changes on a load or an accepted beat.
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(remaining_q))
    else $error("assert_count_hold_R5");

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int unsigned COL_W = 10,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [SEL_W-1:0] len_sel,
  input  logic             addr_ready,
  output logic [COL_W-1:0] col,
  output logic             addr_valid,
  output logic             addr_last
);

  localparam int unsigned LOW_W = burst_col_pkg::wrap_bits(SEL_W);

  logic [LOW_W-1:0] dec_mask;
  logic [LOW_W-1:0] mask_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] col_next;
  logic [COL_W-1:0] seg_mask;
  logic             active_q;
  logic             beat_done;
  logic             ctr_last;

  burst_len_decode #(.SEL_W(SEL_W), .LOW_W(LOW_W)) u_dec (
    .len_sel   (len_sel),
    .wrap_mask (dec_mask)
  );

  burst_wrap_step #(.COL_W(COL_W), .LOW_W(LOW_W)) u_step (
    .cur_col   (col_q),
    .wrap_mask (mask_q),
    .next_col  (col_next)
  );

  assign beat_done = active_q && addr_ready && !start;

  burst_beat_ctr #(.LOW_W(LOW_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (dec_mask),
    .advance  (beat_done),
    .is_last  (ctr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      col_q    <= '0;
      mask_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      col_q    <= start_col;
      mask_q   <= dec_mask;
    end else if (beat_done) begin
      if (ctr_last) begin
        active_q <= 1'b0;
      end else begin
        col_q <= col_next;
      end
    end
  end

  assign col        = col_q;
  assign addr_valid = active_q;
  assign addr_last  = active_q && ctr_last;
  assign seg_mask   = COL_W'(mask_q);

  // R1: nothing is offered before the first start.
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !start) |=> !addr_valid)
    else $error("assert_idle_after_reset_R1");

  // R2: the first beat carries the supplied column.
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr_valid && col == $past(start_col)))
    else $error("assert_first_beat_R2");

  // R3: segment bits never move within a burst.
  assert_segment_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && !addr_last && !start)
      |=> ((col & ~seg_mask) == ($past(col) & ~seg_mask)))
    else $error("assert_segment_fixed_R3");

  // R4: low bits step by one modulo the length.
  assert_low_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && !addr_last && !start)
      |=> ((col[LOW_W-1:0] & mask_q) ==
           (($past(col[LOW_W-1:0]) + LOW_W'(1)) & mask_q)))
    else $error("assert_low_wrap_R4");

  // R5: the burst ends right after the final accepted beat.
  assert_burst_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && addr_last && !start) |=> !addr_valid)
    else $error("assert_burst_ends_R5");

  // R6: last is only flagged on a valid beat.
  assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_last |-> addr_valid)
    else $error("assert_last_needs_valid_R6");

  // R7: back-pressure holds the beat.
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !start)
      |=> (addr_valid && $stable(col) && $stable(addr_last)))
    else $error("assert_stall_hold_R7");

endmodule

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;

  localparam int COL_W = 10;
  localparam int SEL_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [SEL_W-1:0] len_sel = '0;
  logic             addr_ready = 1'b0;
  logic [COL_W-1:0] col;
  logic             addr_valid;
  logic             addr_last;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W), .SEL_W(SEL_W)) u_burst_col_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_col  (start_col),
    .len_sel    (len_sel),
    .addr_ready (addr_ready),
    .col        (col),
    .addr_valid (addr_valid),
    .addr_last  (addr_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int sel, input int k);
    int bl;
    bl = 1 << sel;
    return ((s & ~(bl - 1)) | ((s + k) & (bl - 1))) & ((1 << COL_W) - 1);
  endfunction

  // Issue start at the current negedge; returns at the next negedge with the
  // first beat on the outputs.
  task automatic start_burst(input int s, input int sel);
    start     = 1'b1;
    start_col = COL_W'(s);
    len_sel   = SEL_W'(sel);
    @(negedge clk);
    start = 1'b0;
    chk(addr_valid == 1'b1, "R2 valid", int'(addr_valid), 1);
    chk(int'(col) == s, "R2 first col", int'(col), s);
  endtask

  task automatic run_beats(input int s, input int sel, input int pct, input bit scramble);
    int bl;
    int k;
    bl = 1 << sel;
    k = 0;
    while (k < bl) begin
      logic [COL_W-1:0] held_col;
      logic             held_last;
      bit               rdy;
      chk(addr_valid == 1'b1, "R5 valid in burst", int'(addr_valid), 1);
      chk(int'(col) == exp_col(s, sel, k), "R4 column order", int'(col), exp_col(s, sel, k));
      chk((int'(col) >> sel) == (s >> sel), "R3 segment", int'(col) >> sel, s >> sel);
      chk(addr_last == (k == bl - 1), "R6 last flag", int'(addr_last), int'(k == bl - 1));
      rdy        = (($urandom % 100) < pct);
      addr_ready = rdy;
      held_col   = col;
      held_last  = addr_last;
      @(negedge clk);
      if (scramble) begin
        start_col = COL_W'($urandom);
        len_sel   = SEL_W'($urandom);
      end
      if (rdy) begin
        k++;
      end else begin
        chk(addr_valid && col == held_col && addr_last == held_last,
            "R7 stall hold", int'(col), int'(held_col));
      end
    end
    addr_ready = 1'b0;
    chk(addr_valid == 1'b0, "R5 ends after length", int'(addr_valid), 0);
    chk(addr_last == 1'b0, "R6 last low when idle", int'(addr_last), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R5 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(addr_valid == 1'b0, "R1 valid in reset", int'(addr_valid), 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(addr_valid == 1'b0, "R1 valid after reset", int'(addr_valid), 0);
    chk(addr_last == 1'b0, "R1 last after reset", int'(addr_last), 0);

    // Directed corners.
    start_burst(2, 2);    run_beats(2, 2, 100, 0);     // 2,3,0,1
    start_burst(5, 0);    run_beats(5, 0, 100, 0);     // single beat
    start_burst(1023, 3); run_beats(1023, 3, 100, 0);  // wraps to 1016
    start_burst(7, 3);    run_beats(7, 3, 40, 0);      // wrap with stalls
    start_burst(1, 1);    run_beats(1, 1, 100, 0);     // 1,0

    // R9: inputs scrambled mid-burst.
    start_burst(518, 3);  run_beats(518, 3, 60, 1);

    // R8: abort after one accepted beat.
    start_burst(300, 3);
    addr_ready = 1'b1;
    @(negedge clk);
    chk(int'(col) == exp_col(300, 3, 1), "R8 pre-abort beat", int'(col), exp_col(300, 3, 1));
    start_burst(77, 2);
    run_beats(77, 2, 100, 0);

    // R8: abort while stalled on the first beat.
    start_burst(12, 3);
    addr_ready = 1'b0;
    start_burst(999, 1);
    run_beats(999, 1, 70, 0);

    // Random bursts.
    for (int n = 0; n < 300; n++) begin
      int s;
      int sel;
      s   = int'($urandom % (1 << COL_W));
      sel = int'($urandom % (1 << SEL_W));
      start_burst(s, sel);
      run_beats(s, sel, 30 + int'($urandom % 71), n[0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule